// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Elevation

This block chooses which interrupt request a processor services next. It takes a vector of maskable requests and a small set of nonmaskable requests. Each maskable source has a local enable and an 8-bit vector code, and its rank is fixed by its index. Software can lift any one maskable source to the top of that order by writing the source's vector code into an elevation register. Nonmaskable requests outrank every maskable one and ignore the global mask. Among them, the external nonmaskable pin is gated by a separate X mask.

The processor is modelled only by handshake signals. When a request wins, the controller raises a one-cycle service strobe and latches the vector code. It saves both masks, sets the global I mask and marks itself in service. A return pulse puts back the saved masks, and arbitration resumes on the next cycle. Service is single level. No new strobe is issued while a service is open.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While rst_ni is low and just after it is released, svc_o=0, vec_o=0x00, in_svc_o=0, imask_o=1, xmask_o=1, and the elevation register holds 0xF2.
- R2: Maskable source i is pending when flag_i[i] and en_i[i] are both 1. Its vector code is 0xF2-2*i. Among pending sources a lower index wins. A flag whose enable is 0 is never serviced.
- R3: When the elevation register equals the vector code of a pending maskable source, that source is serviced ahead of all other maskable sources.
- R4: An elevation value that equals no maskable code (odd, above 0xF2 or below 0xB4) leaves the index order unchanged.
- R5: While imask_o=1, pending maskable requests are not serviced. They are serviced once the mask is cleared through imask_we_i/imask_i, which takes effect on the next edge.
- R6: A nonmaskable request beats any maskable one and is serviced whatever imask_o is. crit_req_i index k has code 0xFE-2*k. Index 0 (reset) ranks highest, then 1 (clock failure), 2 (watchdog), 3 (illegal opcode), 4 (software interrupt), 5 (external pin).
- R7: Request index 5 is serviced only while xmask_o=0 and stays pending until then. xmask_clr_i clears xmask_o. Entry for index 5 sets xmask_o.
- R8: A service entry is the edge that follows an eligible request. From that edge svc_o is high for exactly one cycle, in_svc_o is 1 and imask_o is 1. At the entry edge, entry takes precedence over a software write to the I mask.
- R9: rti_i while in_svc_o=1 clears in_svc_o and restores imask_o and xmask_o to the values they held before entry. A further pending request may be entered on the following edge.
- R10: vec_o holds the latched code from the strobe until the next strobe, even if higher requests arrive while in service.
- R11: Nonmaskable requests are captured on their rising edge, so a request held high is serviced once.
- R12: No strobe is issued while in_svc_o=1. Nonmaskable requests arriving in that time stay pending and are serviced after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flag_i | input | 32 | Maskable event flags, held by the sources |
| en_i | input | 32 | Local enables of maskable sources |
| crit_req_i | input | 6 | Nonmaskable requests, rising-edge captured |
| elev_we_i | input | 1 | Write strobe for the elevation register |
| elev_i | input | 8 | Code to elevate |
| imask_we_i | input | 1 | Write strobe for the I mask |
| imask_i | input | 1 | Value written to the I mask |
| xmask_clr_i | input | 1 | Clears the X mask |
| rti_i | input | 1 | Return from service |
| svc_o | output | 1 | One-cycle service strobe |
| vec_o | output | 8 | Latched vector code |
| in_svc_o | output | 1 | Service open |
| imask_o | output | 1 | Global I mask |
| xmask_o | output | 1 | X mask |

## Verification
Two actions can share one edge: a service entry, and a software write or return that changes the masks. The bench provokes this by asserting imask_we_i with a clear value in the same cycle a maskable request becomes eligible. The entry must win, so the I mask reads 1 afterwards. A second collision is a nonmaskable request arriving while a service is open, or a level held across the return. Both are judged by counting strobes at the ports and reading back the code and masks after rti_i.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum int unsigned {
    CRIT_RST  = 0,
    CRIT_CLK  = 1,
    CRIT_WDOG = 2,
    CRIT_TRAP = 3,
    CRIT_SWI  = 4,
    CRIT_XPIN = 5
  } crit_idx_e;

  localparam int unsigned NUM_CRIT = 6;
endpackage

// File: rtl/irq_crit_arb.sv
module irq_crit_arb
  import irq_pkg::*;
#(
  parameter int unsigned NCRIT  = NUM_CRIT,
  parameter int unsigned CBASE  = 8'hFE,
  parameter int unsigned XIDX   = NCRIT - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCRIT-1:0] req_i,
  input  logic             xmask_i,
  input  logic             take_i,
  output logic             valid_o,
  output code_t            code_o,
  output logic             is_x_o
);
  logic [NCRIT-1:0] req_q, pend_q, elig, sel;

  always_comb begin
    elig = pend_q;
    elig[XIDX] = pend_q[XIDX] & ~xmask_i;
  end

  always_comb begin
    sel    = '0;
    code_o = '0;
    for (int k = NCRIT - 1; k >= 0; k--) begin
      if (elig[k]) begin
        sel    = '0;
        sel[k] = 1'b1;
        code_o = code_t'(CBASE - 2 * k);
      end
    end
  end

  assign valid_o = |elig;
  assign is_x_o  = sel[XIDX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~(sel & {NCRIT{take_i}})) | (req_i & ~req_q);
    end
  end
endmodule

// File: rtl/irq_mask_arb.sv
module irq_mask_arb
  import irq_pkg::*;
#(
  parameter int unsigned NSRC     = 32,
  parameter int unsigned MBASE    = 8'hF2,
  parameter int unsigned ELEV_RST = 8'hF2,
  localparam int unsigned IDX_W   = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] flag_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            elev_we_i,
  input  code_t           elev_i,
  output logic            valid_o,
  output code_t           code_o
);
  code_t           elev_q;
  logic [NSRC-1:0] pend, hit;
  logic [IDX_W-1:0] fix_idx, elev_idx;
  logic            elev_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        elev_q <= code_t'(ELEV_RST);
    else if (elev_we_i) elev_q <= elev_i;
  end

  assign pend = flag_i & en_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hit[i] = (elev_q == code_t'(MBASE - 2 * i));
  end

  always_comb begin
    fix_idx  = '0;
    elev_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) fix_idx = IDX_W'(i);
      if (hit[i])  elev_idx = IDX_W'(i);
    end
  end

  assign elev_ok = |(hit & pend);
  assign valid_o = |pend;
  assign code_o  = code_t'(MBASE - 2 * (elev_ok ? elev_idx : fix_idx));
endmodule

// File: rtl/irq_svc_ctl.sv
module irq_svc_ctl
  import irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  crit_valid_i,
  input  code_t crit_code_i,
  input  logic  crit_is_x_i,
  input  logic  mask_valid_i,
  input  code_t mask_code_i,
  input  logic  imask_we_i,
  input  logic  imask_i,
  input  logic  xmask_clr_i,
  input  logic  rti_i,
  output logic  take_crit_o,
  output logic  svc_o,
  output code_t vec_o,
  output logic  in_svc_o,
  output logic  imask_o,
  output logic  xmask_o
);
  logic go, sav_i_q, sav_x_q;

  assign go          = !in_svc_o && (crit_valid_i || (mask_valid_i && !imask_o));
  assign take_crit_o = go && crit_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_o    <= 1'b0;
      vec_o    <= '0;
      in_svc_o <= 1'b0;
      imask_o  <= 1'b1;
      xmask_o  <= 1'b1;
      sav_i_q  <= 1'b1;
      sav_x_q  <= 1'b1;
    end else begin
      svc_o <= go;
      if (go) begin
        vec_o    <= crit_valid_i ? crit_code_i : mask_code_i;
        in_svc_o <= 1'b1;
        sav_i_q  <= imask_o;
        sav_x_q  <= xmask_o;
        imask_o  <= 1'b1;
        if (crit_valid_i && crit_is_x_i) xmask_o <= 1'b1;
      end else if (rti_i && in_svc_o) begin
        in_svc_o <= 1'b0;
        imask_o  <= sav_i_q;
        xmask_o  <= sav_x_q;
      end else begin
        if (imask_we_i)  imask_o <= imask_i;
        if (xmask_clr_i) xmask_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NSRC     = 32,
  parameter int unsigned NCRIT    = NUM_CRIT,
  parameter int unsigned MBASE    = 8'hF2,
  parameter int unsigned CBASE    = 8'hFE,
  parameter int unsigned ELEV_RST = 8'hF2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   flag_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [NCRIT-1:0]  crit_req_i,
  input  logic              elev_we_i,
  input  logic [CODE_W-1:0] elev_i,
  input  logic              imask_we_i,
  input  logic              imask_i,
  input  logic              xmask_clr_i,
  input  logic              rti_i,
  output logic              svc_o,
  output logic [CODE_W-1:0] vec_o,
  output logic              in_svc_o,
  output logic              imask_o,
  output logic              xmask_o
);
  logic  crit_valid, crit_is_x, mask_valid, take_crit;
  code_t crit_code, mask_code;

  irq_crit_arb #(.NCRIT(NCRIT), .CBASE(CBASE)) u_crit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (crit_req_i),
    .xmask_i (xmask_o),
    .take_i  (take_crit),
    .valid_o (crit_valid),
    .code_o  (crit_code),
    .is_x_o  (crit_is_x)
  );

  irq_mask_arb #(.NSRC(NSRC), .MBASE(MBASE), .ELEV_RST(ELEV_RST)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_i    (flag_i),
    .en_i      (en_i),
    .elev_we_i (elev_we_i),
    .elev_i    (elev_i),
    .valid_o   (mask_valid),
    .code_o    (mask_code)
  );

  irq_svc_ctl u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .crit_valid_i (crit_valid),
    .crit_code_i  (crit_code),
    .crit_is_x_i  (crit_is_x),
    .mask_valid_i (mask_valid),
    .mask_code_i  (mask_code),
    .imask_we_i   (imask_we_i),
    .imask_i      (imask_i),
    .xmask_clr_i  (xmask_clr_i),
    .rti_i        (rti_i),
    .take_crit_o  (take_crit),
    .svc_o        (svc_o),
    .vec_o        (vec_o),
    .in_svc_o     (in_svc_o),
    .imask_o      (imask_o),
    .xmask_o      (xmask_o)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned CRIT_LOW = 8'hF4,
  parameter int unsigned XCODE    = 8'hF4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       svc_o,
  input logic [7:0] vec_o,
  input logic       in_svc_o,
  input logic       imask_o,
  input logic       xmask_o,
  input logic       rti_i
);
  assert_strobe_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |=> !svc_o);

  assert_entry_sets_imask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |-> (imask_o && in_svc_o));

  assert_vec_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_svc_o && !rti_i) |=> $stable(vec_o));

  assert_single_level_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |-> !$past(in_svc_o));

  assert_imask_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_o && $past(imask_o)) |-> (vec_o >= 8'(CRIT_LOW)));

  assert_xmask_gates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_o && vec_o == 8'(XCODE)) |-> !$past(xmask_o));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .svc_o    (svc_o),
  .vec_o    (vec_o),
  .in_svc_o (in_svc_o),
  .imask_o  (imask_o),
  .xmask_o  (xmask_o),
  .rti_i    (rti_i)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] flag_i = '0, en_i = '0;
  logic [5:0]  crit_req_i = '0;
  logic        elev_we_i = 0, imask_we_i = 0, imask_i = 0, xmask_clr_i = 0, rti_i = 0;
  logic [7:0]  elev_i = '0;
  logic        svc_o, in_svc_o, imask_o, xmask_o;
  logic [7:0]  vec_o;
  int errors = 0, checks = 0, svc_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .flag_i(flag_i), .en_i(en_i),
    .crit_req_i(crit_req_i), .elev_we_i(elev_we_i), .elev_i(elev_i),
    .imask_we_i(imask_we_i), .imask_i(imask_i), .xmask_clr_i(xmask_clr_i),
    .rti_i(rti_i), .svc_o(svc_o), .vec_o(vec_o), .in_svc_o(in_svc_o),
    .imask_o(imask_o), .xmask_o(xmask_o)
  );

  always @(negedge clk) if (rst_ni && svc_o) svc_cnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask(logic [31:0] p, logic [7:0] elev);
    int w = 0;
    for (int i = 31; i >= 0; i--) if (p[i]) w = i;
    for (int i = 0; i < 32; i++) if (elev == 8'(8'hF2 - 2*i) && p[i]) w = i;
    return 8'(8'hF2 - 2*w);
  endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic do_rti();
    rti_i = 1; step(); rti_i = 0;
  endtask

  task automatic trial();
    logic [31:0] f, e;
    logic [7:0]  el, exp;
    int k;
    bit use_crit;
    f = $urandom & $urandom & $urandom;
    e = $urandom | $urandom;
    if ((f & e) == 0) begin k = $urandom % 32; f[k] = 1; e[k] = 1; end
    el = ($urandom % 2) ? 8'(8'hF2 - 2 * ($urandom % 32)) : 8'($urandom);
    use_crit = ($urandom % 4) == 0;
    k = $urandom % 6;
    elev_we_i = 1; elev_i = el; imask_we_i = 1; imask_i = 0; xmask_clr_i = 1;
    flag_i = 0; en_i = 0; crit_req_i = use_crit ? 6'(1 << k) : 6'd0;
    step();
    elev_we_i = 0; imask_we_i = 0; xmask_clr_i = 0; crit_req_i = 0;
    flag_i = f; en_i = e;
    exp = use_crit ? 8'(8'hFE - 2*k) : exp_mask(f & e, el);
    step();
    if (use_crit) check("R6 nonmaskable first", vec_o, exp);
    else if (el >= 8'hB4 && el <= 8'hF2 && !el[0]) check("R3 elevated code", vec_o, exp);
    else check("R4 unmatched elevation", vec_o, exp);
    check("R8 strobe", svc_o, 1);
    check("R8 imask set", imask_o, 1);
    flag_i = '1; en_i = '1;
    step();
    check("R10 vec held", vec_o, exp);
    check("R12 no strobe in service", svc_o, 0);
    flag_i = 0;
    do_rti();
    check("R9 in_svc cleared", in_svc_o, 0);
    check("R9 imask restored", imask_o, 0);
    check("R9 xmask restored", xmask_o, 0);
    step();
    check("R2 idle after return", svc_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R1 svc", svc_o, 0); check("R1 vec", vec_o, 0);
    check("R1 in_svc", in_svc_o, 0); check("R1 imask", imask_o, 1);
    check("R1 xmask", xmask_o, 1);
    rst_ni = 1;
    step();
    // R5: I mask held from reset blocks a pending source
    flag_i[5] = 1; en_i[5] = 1;
    repeat (3) step();
    check("R5 blocked while I set", svc_cnt, 0);
    imask_we_i = 1; imask_i = 0; step(); imask_we_i = 0;
    step();
    check("R5 serviced after clear", svc_o, 1);
    check("R2 code of source 5", vec_o, 8'hE8);
    flag_i = 0; do_rti();
    // R2: flags without enable are ignored
    flag_i = '1; en_i = 0; c = svc_cnt;
    repeat (3) step();
    check("R2 disabled flags ignored", svc_cnt, c);
    flag_i = 0;
    // R1: default elevation selects source 0 ahead of 9
    flag_i[9] = 1; en_i[9] = 1; flag_i[0] = 1; en_i[0] = 1;
    step();
    check("R1 default top source", vec_o, 8'hF2);
    flag_i = 0; do_rti();
    // R7: external pin waits for X clear
    c = svc_cnt;
    crit_req_i[5] = 1; step(); crit_req_i[5] = 0;
    repeat (3) step();
    check("R7 gated by X", svc_cnt, c);
    xmask_clr_i = 1; step(); xmask_clr_i = 0;
    step();
    check("R7 pin serviced", vec_o, 8'hF4);
    check("R7 entry sets X", xmask_o, 1);
    do_rti();
    check("R7 X restored clear", xmask_o, 0);
    step();
    for (int t = 0; t < 200; t++) trial();
    // R11: held request serviced once
    c = svc_cnt;
    crit_req_i[3] = 1; step(); step();
    check("R6 trap code", vec_o, 8'hF8);
    // R12: reset request while in service waits
    crit_req_i[0] = 1; step(); crit_req_i[0] = 0;
    repeat (2) step();
    check("R12 no strobe in service", svc_cnt, c + 1);
    do_rti(); step();
    check("R12 pending reset request served", vec_o, 8'hFE);
    do_rti(); repeat (3) step();
    check("R11 held request once", svc_cnt, c + 2);
    crit_req_i = 0;
    // R9/R6: nonmaskable entry with I set restores I=1
    imask_we_i = 1; imask_i = 1; step(); imask_we_i = 0;
    crit_req_i[1] = 1; step(); crit_req_i[1] = 0; step();
    check("R6 clock failure under I", vec_o, 8'hFC);
    do_rti();
    check("R9 imask restored set", imask_o, 1);
    // R8: entry beats same-cycle mask write
    imask_we_i = 1; imask_i = 0; step(); imask_we_i = 0;
    flag_i[2] = 1; en_i[2] = 1; imask_we_i = 1; imask_i = 0;
    step(); imask_we_i = 0;
    check("R8 entry wins mask write", imask_o, 1);
    check("R8 strobe on collision", vec_o, 8'hEE);
    flag_i = 0; do_rti();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule